// File: doc/BRIEF.md
# Decimal partial product generator

This block produces the two radix-10 partial products that one multiplier digit contributes in a parallel BCD multiplier. It takes an N-digit BCD multiplicand and a single BCD multiplier digit. The digit is split into a high part worth 0, 5 or 10 and a low part worth -2 to +2. The block returns one vector for each part, and the carry-save tree downstream adds these vectors.

Only four multiples of the multiplicand are needed: 1x, 2x, 5x and 10x. 10x is a pure one-digit shift. Doubling uses a carry that moves at most one digit position. The times-five multiple is built digit by digit from the parity of the neighbouring shifted digit, so it has no carry chain at all.

A negative low part is given as the digit-wise nine's complement of the chosen multiple. A separate correction bit supplies the missing +1, and the accumulation tree absorbs that bit as a carry-in. Both output vectors are N+1 digits wide. An optional output register, selected by a parameter, lets the block sit at a pipeline boundary.

Top module: `dpp_gen`

## Requirements
- R1: `hi_o` is zero for digits 0, 1 and 2. It is 5x for digits 3 to 7 and 10x for digits 8 and 9.
- R2: `lo_o` is zero for digits 0 and 5, and x for digits 1 and 6. It is 2x for digits 2 and 7. It is the nine's complement of 2x for digits 3 and 8, and the nine's complement of x for digits 4 and 9.
- R3: 10x equals x moved up one digit position, with a zero in digit 0.
- R4: Digit i of 2x equals (2·x_i mod 10) plus 1 when x_(i-1) ≥ 5. Digit N holds only the carry out of digit N-1.
- R5: Digit i of 5x equals floor(s_i/2) plus 5 when s_(i+1) is odd, where s = 10x. Digit 0 of 5x is therefore always 0 or 5.
- R6: A complemented low vector has every digit equal to 9 minus the multiple's digit, over all N+1 digits. Digit N is therefore 9 or 8.
- R7: `cor_o` is 1 exactly for digits 3, 4, 8 and 9. It is never 1 while `lo_o` is all zero.
- R8: The integer value of `hi_o`, plus the integer value of `lo_o`, plus `cor_o`, taken modulo 10^(N+1), equals x·y.
- R9: Every digit of `hi_o` and `lo_o` is in the range 0..9. Digits are packed 4 bits each, with digit 0 in bits [3:0].
- R10: With REG_OUT=1 the outputs follow the inputs one rising clock edge later. While `rst_ni` is low the outputs are all zero. With REG_OUT=0 the outputs are combinational and the clock and reset are unused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| x_i | input | 4*N | BCD multiplicand, digit 0 in bits [3:0] |
| y_i | input | 4 | BCD multiplier digit |
| hi_o | output | 4*(N+1) | High partial product: 0, 5x or 10x |
| lo_o | output | 4*(N+1) | Low partial product, nine's complemented when negative |
| cor_o | output | 1 | +1 correction that completes the ten's complement |

## Verification
The bench builds the block with the default N=16 and REG_OUT=1. With this setting a 17-digit result still fits in a 64-bit integer, so the bench can check every vector against plain integer arithmetic. The registered build also makes the one-cycle latency and the reset clearing observable. The multiplicand patterns are all fives, all nines, alternating odd and even digits, a lone unit digit and random digits. These patterns drive the doubling carry into every position, drive the times-five parity term into every position, and make digit N carry a nonzero value.

// File: rtl/dpp_pkg.sv
package dpp_pkg;
  typedef enum logic [1:0] {HI_ZERO, HI_FIVE, HI_TEN} hi_sel_e;
  typedef enum logic [1:0] {LO_ZERO, LO_ONE, LO_TWO} lo_mag_e;

  typedef struct packed {
    hi_sel_e hi;
    lo_mag_e lo;
    logic    neg;
  } rec_t;

  // 2*d mod 10 for a BCD digit
  function automatic logic [3:0] dbl_mod10(input logic [3:0] d);
    logic [4:0] t;
    t = {d, 1'b0};
    return (t >= 5'd10) ? 4'(t - 5'd10) : t[3:0];
  endfunction
endpackage

// File: rtl/dpp_recode.sv
module dpp_recode
  import dpp_pkg::*;
(
  input  logic [3:0] digit_i,
  output rec_t       rec_o
);
  always_comb begin
    unique case (digit_i)
      4'd1:    rec_o = '{HI_ZERO, LO_ONE,  1'b0};
      4'd2:    rec_o = '{HI_ZERO, LO_TWO,  1'b0};
      4'd3:    rec_o = '{HI_FIVE, LO_TWO,  1'b1};
      4'd4:    rec_o = '{HI_FIVE, LO_ONE,  1'b1};
      4'd5:    rec_o = '{HI_FIVE, LO_ZERO, 1'b0};
      4'd6:    rec_o = '{HI_FIVE, LO_ONE,  1'b0};
      4'd7:    rec_o = '{HI_FIVE, LO_TWO,  1'b0};
      4'd8:    rec_o = '{HI_TEN,  LO_TWO,  1'b1};
      4'd9:    rec_o = '{HI_TEN,  LO_ONE,  1'b1};
      default: rec_o = '{HI_ZERO, LO_ZERO, 1'b0};
    endcase
  end
endmodule

// File: rtl/dpp_multiples.sv
module dpp_multiples
  import dpp_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [4*N-1:0]     x_i,
  output logic [4*(N+1)-1:0] x1_o,
  output logic [4*(N+1)-1:0] x2_o,
  output logic [4*(N+1)-1:0] x5_o,
  output logic [4*(N+1)-1:0] x10_o
);
  localparam int W = N + 1;

  assign x1_o  = {4'd0, x_i};
  assign x10_o = {x_i, 4'd0};

  for (genvar i = 0; i < W; i++) begin : g_dig
    logic [3:0] xd, sd;
    assign xd = x1_o[4*i +: 4];
    assign sd = x10_o[4*i +: 4];

    // doubling: carry from the lower digit reaches one position only
    if (i == 0) begin : g_d0
      assign x2_o[3:0] = dbl_mod10(xd);
    end else begin : g_dn
      logic cin;
      assign cin = (x1_o[4*(i-1) +: 4] >= 4'd5);
      assign x2_o[4*i +: 4] = dbl_mod10(xd) + {3'd0, cin};
    end

    // times five = (10x)/2, parity of the next-up shifted digit adds 5
    if (i == W - 1) begin : g_ftop
      assign x5_o[4*i +: 4] = {1'b0, sd[3:1]};
    end else begin : g_fn
      logic odd_up;
      assign odd_up = x10_o[4*(i+1)];
      assign x5_o[4*i +: 4] = {1'b0, sd[3:1]} + (odd_up ? 4'd5 : 4'd0);
    end
  end
endmodule

// File: rtl/dpp_select.sv
module dpp_select
  import dpp_pkg::*;
#(
  parameter int N = 16
) (
  input  rec_t               rec_i,
  input  logic [4*(N+1)-1:0] x1_i,
  input  logic [4*(N+1)-1:0] x2_i,
  input  logic [4*(N+1)-1:0] x5_i,
  input  logic [4*(N+1)-1:0] x10_i,
  output logic [4*(N+1)-1:0] hi_o,
  output logic [4*(N+1)-1:0] lo_o,
  output logic               cor_o
);
  localparam int W = N + 1;

  logic [4*W-1:0] mag, mag_c;

  always_comb begin
    unique case (rec_i.hi)
      HI_FIVE: hi_o = x5_i;
      HI_TEN:  hi_o = x10_i;
      default: hi_o = '0;
    endcase
    unique case (rec_i.lo)
      LO_ONE:  mag = x1_i;
      LO_TWO:  mag = x2_i;
      default: mag = '0;
    endcase
  end

  for (genvar i = 0; i < W; i++) begin : g_cmp
    assign mag_c[4*i +: 4] = 4'd9 - mag[4*i +: 4];
  end

  logic neg_eff;
  assign neg_eff = rec_i.neg && (rec_i.lo != LO_ZERO);
  assign lo_o    = neg_eff ? mag_c : mag;
  assign cor_o   = neg_eff;
endmodule

// File: rtl/dpp_gen.sv
module dpp_gen
  import dpp_pkg::*;
#(
  parameter int N       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [4*N-1:0]     x_i,
  input  logic [3:0]         y_i,
  output logic [4*(N+1)-1:0] hi_o,
  output logic [4*(N+1)-1:0] lo_o,
  output logic               cor_o
);
  localparam int W = N + 1;

  rec_t           rec;
  logic [4*W-1:0] x1, x2, x5, x10, hi_d, lo_d;
  logic           cor_d;

  dpp_recode u_rec (.digit_i(y_i), .rec_o(rec));

  dpp_multiples #(.N(N)) u_mul (
    .x_i(x_i), .x1_o(x1), .x2_o(x2), .x5_o(x5), .x10_o(x10)
  );

  dpp_select #(.N(N)) u_sel (
    .rec_i(rec), .x1_i(x1), .x2_i(x2), .x5_i(x5), .x10_i(x10),
    .hi_o(hi_d), .lo_o(lo_d), .cor_o(cor_d)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_o  <= '0;
        lo_o  <= '0;
        cor_o <= 1'b0;
      end else begin
        hi_o  <= hi_d;
        lo_o  <= lo_d;
        cor_o <= cor_d;
      end
    end
  end else begin : g_comb
    assign hi_o  = hi_d;
    assign lo_o  = lo_d;
    assign cor_o = cor_d;
  end
endmodule

// File: rtl/dpp_gen_chk.sv
module dpp_gen_chk #(
  parameter int N       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [3:0]         y_i,
  input logic [4*(N+1)-1:0] hi_o,
  input logic [4*(N+1)-1:0] lo_o,
  input logic               cor_o
);
  localparam int W = N + 1;

  function automatic logic all_bcd(input logic [4*W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < W; i++) if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic neg_digit(input logic [3:0] d);
    return (d == 4'd3) || (d == 4'd4) || (d == 4'd8) || (d == 4'd9);
  endfunction

  assert_digits_bcd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_bcd(hi_o) && all_bcd(lo_o));

  assert_cor_top_digit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cor_o |-> (lo_o[4*W-1 -: 4] >= 4'd8));

  assert_cor_nonzero_lo_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cor_o |-> (lo_o != '0));

  assert_five_unit_digit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_o[3:0] == 4'd0) || (hi_o[3:0] == 4'd5));

  if (REG_OUT) begin : g_reg_chk
    assert_reset_clear_R10: assert property (@(posedge clk_i)
      !rst_ni |-> (hi_o == '0 && lo_o == '0 && !cor_o));

    assert_cor_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> (cor_o == $past(neg_digit(y_i))));
  end else begin : g_comb_chk
    assert_cor_comb_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cor_o == neg_digit(y_i));
  end
endmodule

bind dpp_gen dpp_gen_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .y_i(y_i),
  .hi_o(hi_o), .lo_o(lo_o), .cor_o(cor_o)
);

// File: tb/dpp_gen_bench.sv
module dpp_gen_bench;
  localparam int N      = 16;
  localparam int W      = N + 1;
  localparam int PERIOD = 10;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [4*N-1:0] x_i = '0;
  logic [3:0]     y_i = '0;
  logic [4*W-1:0] hi_o, lo_o;
  logic           cor_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(PERIOD/2) clk_i = ~clk_i;

  dpp_gen #(.N(N), .REG_OUT(1'b1)) u_dpp_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .x_i(x_i), .y_i(y_i),
    .hi_o(hi_o), .lo_o(lo_o), .cor_o(cor_o)
  );

  function automatic longint unsigned pow10(input int k);
    longint unsigned p = 1;
    for (int i = 0; i < k; i++) p = p * 10;
    return p;
  endfunction

  function automatic longint unsigned to_int(input logic [4*W-1:0] v);
    longint unsigned r = 0;
    for (int i = W - 1; i >= 0; i--) r = r * 10 + longint'(v[4*i +: 4]);
    return r;
  endfunction

  function automatic bit bcd_ok(input logic [4*W-1:0] v);
    for (int i = 0; i < W; i++) if (v[4*i +: 4] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive one digit, check after the register edge
  task automatic check_digit(input logic [4*N-1:0] x, input int y);
    longint unsigned xv, mod, hexp, lexp, sum;
    bit cexp;
    @(negedge clk_i);
    x_i = x;
    y_i = 4'(y);
    @(negedge clk_i);
    xv   = to_int({4'd0, x});
    mod  = pow10(W);
    hexp = (y < 3) ? 0 : (y < 8) ? 5 * xv : 10 * xv;
    case (y)
      1, 6:    lexp = xv;
      2, 7:    lexp = 2 * xv;
      3, 8:    lexp = (mod - 1) - 2 * xv;
      4, 9:    lexp = (mod - 1) - xv;
      default: lexp = 0;
    endcase
    cexp = (y == 3 || y == 4 || y == 8 || y == 9);
    chk(bcd_ok(hi_o) && bcd_ok(lo_o), "R9 digits", to_int(hi_o), hexp);
    chk(to_int(hi_o) == hexp, (y >= 8) ? "R1/R3 hi=10x" : "R1/R5 hi", to_int(hi_o), hexp);
    chk(to_int(lo_o) == lexp, cexp ? "R2/R6 lo complement" : "R2/R4 lo", to_int(lo_o), lexp);
    chk(cor_o == cexp, "R7 cor", longint'(cor_o), longint'(cexp));
    sum = (to_int(hi_o) + to_int(lo_o) + longint'(cor_o)) % mod;
    chk(sum == xv * longint'(y), "R8 sum", sum, xv * longint'(y));
  endtask

  task automatic sweep(input logic [4*N-1:0] x);
    for (int y = 0; y < 10; y++) check_digit(x, y);
  endtask

  function automatic logic [4*N-1:0] fill(input logic [3:0] a, input logic [3:0] b);
    logic [4*N-1:0] v;
    for (int i = 0; i < N; i++) v[4*i +: 4] = (i % 2 == 0) ? a : b;
    return v;
  endfunction

  task automatic t_reset();
    #1;
    chk(hi_o == '0 && lo_o == '0 && cor_o == 1'b0, "R10 reset state",
        to_int(hi_o) + to_int(lo_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_patterns();
    sweep(fill(4'd5, 4'd5));
    sweep(fill(4'd9, 4'd9));
    sweep(fill(4'd1, 4'd8));
    sweep(fill(4'd7, 4'd2));
    sweep({4'd1, {(4*N-4){1'b0}}});
    sweep({{(4*N-4){1'b0}}, 4'd1});
    sweep('0);
  endtask

  task automatic t_random();
    logic [4*N-1:0] x;
    for (int k = 0; k < 40; k++) begin
      for (int i = 0; i < N; i++) x[4*i +: 4] = 4'($urandom % 10);
      if (x[4*N-1 -: 4] == 4'd0) x[4*N-1 -: 4] = 4'd1;
      sweep(x);
    end
  endtask

  task automatic t_latency();
    logic [4*N-1:0] x;
    longint unsigned ten;
    x = fill(4'd3, 4'd6);
    check_digit(x, 9);
    ten = 10 * to_int({4'd0, x});
    @(negedge clk_i);
    y_i = 4'd0;
    #1;
    chk(to_int(hi_o) == ten, "R10 held until edge", to_int(hi_o), ten);
    @(negedge clk_i);
    chk(hi_o == '0 && lo_o == '0, "R10 after edge", to_int(hi_o), 0);
    y_i = 4'd8;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(hi_o == '0 && lo_o == '0 && !cor_o, "R10 async clear",
        to_int(hi_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_patterns();
    t_random();
    t_latency();
    finish_run();
  end

  initial begin
    #(PERIOD * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule